// File: doc/BRIEF.md
# Dual-Protocol Mode Transition Controller

This block chooses which of two serial protocols a display-identification memory answers on. After reset it sits in a one-way streaming mode, in which a separate streamer shifts memory contents out, clocked by the slow VCLK line. A high-to-low edge on the two-wire bus clock (SCL) moves it into a probing state. There it watches the bus for a START condition followed by the device control byte. While it waits, it counts VCLK pulses so that it can fall back to streaming.

A control byte whose upper seven bits match the device identity locks the controller into the bidirectional two-wire mode. The controller acknowledges that byte and stays in that mode until reset. If no matching byte arrives and 128 VCLK pulses accumulate while SCL is idle, streaming resumes from the first bit of the first address. A mode-select output and a streamer-enable output steer the external slave engine and the streamer. A write qualifier tells the slave engine when writes are allowed. All three bus lines are asynchronous. Each is synchronised into the system clock domain before any edge is detected. Control pins are plain levels and pulses, with no handshake.

Top module: `mode_xfer_ctrl`

## Requirements
- R1: After reset, mode_o is streaming, stream_en_o is 1, and sda_oe_o, wr_allow_o and restart_o are 0.
- R2: mode_o encodes streaming as 2'b00, probing as 2'b01 and bidirectional as 2'b10. The controller leaves streaming only on an SCL high-to-low edge, and then enters probing with stream_en_o at 0.
- R3: In probing, each VCLK rising edge adds one to a pulse count. While the count is below 128 the mode is unchanged. When the count reaches 128 with SCL high, the mode returns to streaming and restart_o pulses high for exactly one clock, telling the streamer to begin again at the MSB of address 0.
- R4: Every SCL high-to-low edge in probing clears the pulse count to zero.
- R5: If the count reaches 128 while SCL is low, the count holds and probing continues until SCL returns high.
- R6: A START is SDA falling while SCL is high. The next eight SCL rising edges sample SDA MSB first. If the first seven bits equal 1010000, the mode becomes bidirectional, whatever the eighth (read/write) bit is.
- R7: A control byte that does not match leaves the controller in probing, and the VCLK timeout still returns it to streaming.
- R8: On a matching byte, sda_oe_o goes high after the SCL falling edge that ends the eighth bit. It stays high through the ninth clock and drops at the SCL falling edge that ends it. A non-matching byte never raises sda_oe_o.
- R9: Bidirectional mode is permanent: VCLK pulses, SCL edges and further bus traffic (which is not acknowledged) leave it unchanged. Only reset leaves it.
- R10: wr_allow_o is 1 only in bidirectional mode while the synchronised VCLK level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, power-on equivalent |
| vclk_i | input | 1 | Streaming clock line, asynchronous |
| scl_i | input | 1 | Two-wire bus clock, asynchronous |
| sda_i | input | 1 | Two-wire bus data as seen on the wire, asynchronous |
| mode_o | output | 2 | Current mode: 00 streaming, 01 probing, 10 bidirectional |
| stream_en_o | output | 1 | High while the streamer may drive data |
| restart_o | output | 1 | One-clock pulse: streamer restarts at MSB of address 0 |
| wr_allow_o | output | 1 | Write qualifier for the bidirectional slave engine |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge of the control byte) |

## Verification
The assertions assume the bus lines move slowly compared with clk, so that every level lasts longer than the synchroniser plus the edge register. They also assume SDA changes while SCL is high only to form a START or STOP. The stimulus holds every VCLK, SCL and SDA level for at least three system clocks. It changes SDA only while SCL is low, except at deliberate START and STOP points. It models the open-drain wire by ANDing the master's SDA with the inverse of sda_oe_o.

// File: rtl/mxc_pkg.sv
package mxc_pkg;

  typedef enum logic [1:0] {
    MODE_STREAM = 2'b00,
    MODE_PROBE  = 2'b01,
    MODE_BIDIR  = 2'b10
  } mode_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_JUDGE,
    RX_ACK
  } rx_e;

  localparam int LINE_VCLK = 0;
  localparam int LINE_SCL  = 1;
  localparam int LINE_SDA  = 2;
  localparam int LINE_CNT  = 3;

endpackage

// File: rtl/mxc_in_sync.sv
module mxc_in_sync #(
  parameter int              N      = 3,
  parameter int              STAGES = 2,
  parameter logic [N-1:0]    IDLE   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prev_o
);

  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [DEPTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {DEPTH{IDLE[g]}};
      else        pipe <= {pipe[DEPTH-2:0], raw_i[g]};
    end

    assign lvl_o[g]  = pipe[STAGES-1];
    assign prev_o[g] = pipe[STAGES];
  end

endmodule

// File: rtl/mxc_pulse_cnt.sv
module mxc_pulse_cnt #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic step_i,
  output logic hit_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CAP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clear_i)             cnt <= '0;
    else if (step_i && cnt != CAP) cnt <= cnt + 1'b1;
  end

  assign hit_o = (cnt == CAP);

  p_cnt_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt == '0));

  p_cnt_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CAP);

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !clear_i) |=> hit_o);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !step_i) |=> $stable(cnt));

endmodule

// File: rtl/mxc_addr_rx.sv
module mxc_addr_rx
  import mxc_pkg::*;
#(
  parameter int             W       = 8,
  parameter logic [W-2:0]   CTRL_ID = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic listen_i,
  input  logic scl_lvl_i,
  input  logic scl_rise_i,
  input  logic scl_fall_i,
  input  logic sda_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic hit_o,
  output logic oe_o
);

  localparam int BW = $clog2(W + 1);
  localparam logic [BW-1:0] LAST = BW'(W - 1);

  rx_e           st;
  logic [BW-1:0] bits;
  logic [W-1:0]  shreg;
  logic          start_c, stop_c, id_ok;

  assign start_c = sda_fall_i && scl_lvl_i;
  assign stop_c  = sda_rise_i && scl_lvl_i;
  assign id_ok   = (shreg[W-1:1] == CTRL_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      bits  <= '0;
      shreg <= '0;
      hit_o <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          if (listen_i && start_c) begin
            st   <= RX_SHIFT;
            bits <= '0;
          end
        end
        RX_SHIFT: begin
          if (start_c) begin
            bits <= '0;
          end else if (stop_c) begin
            st <= RX_IDLE;
          end else if (scl_rise_i) begin
            shreg <= {shreg[W-2:0], sda_lvl_i};
            bits  <= bits + 1'b1;
            if (bits == LAST) st <= RX_JUDGE;
          end
        end
        RX_JUDGE: begin
          if (start_c) begin
            st   <= RX_SHIFT;
            bits <= '0;
          end else if (stop_c) begin
            st <= RX_IDLE;
          end else if (scl_fall_i) begin
            if (id_ok && listen_i) begin
              st    <= RX_ACK;
              hit_o <= 1'b1;
            end else begin
              st <= RX_IDLE;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall_i || stop_c) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign oe_o = (st == RX_ACK);

  p_ack_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(scl_fall_i));

  p_ack_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && scl_fall_i) |=> !oe_o);

  p_shift_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_SHIFT) |-> (bits < BW'(W)));

  p_hit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);

endmodule

// File: rtl/mode_xfer_ctrl.sv
module mode_xfer_ctrl
  import mxc_pkg::*;
#(
  parameter int         TIMEOUT_PULSES = 128,
  parameter int         SYNC_STAGES    = 2,
  parameter logic [6:0] CTRL_ID        = 7'b1010000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vclk_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic [1:0] mode_o,
  output logic       stream_en_o,
  output logic       restart_o,
  output logic       wr_allow_o,
  output logic       sda_oe_o
);

  localparam int BYTE_W = 8;

  logic [LINE_CNT-1:0] raw, lvl, prev;
  logic vclk_rise, scl_rise, scl_fall, sda_rise, sda_fall;
  logic to_hit, id_hit, cnt_clear;
  mode_e mode_q;
  logic  restart_q;

  assign raw[LINE_VCLK] = vclk_i;
  assign raw[LINE_SCL]  = scl_i;
  assign raw[LINE_SDA]  = sda_i;

  mxc_in_sync #(
    .N      (LINE_CNT),
    .STAGES (SYNC_STAGES),
    .IDLE   ('1)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign vclk_rise = lvl[LINE_VCLK] & ~prev[LINE_VCLK];
  assign scl_rise  = lvl[LINE_SCL]  & ~prev[LINE_SCL];
  assign scl_fall  = ~lvl[LINE_SCL] &  prev[LINE_SCL];
  assign sda_rise  = lvl[LINE_SDA]  & ~prev[LINE_SDA];
  assign sda_fall  = ~lvl[LINE_SDA] &  prev[LINE_SDA];

  assign cnt_clear = (mode_q != MODE_PROBE) || scl_fall;

  mxc_pulse_cnt #(
    .LIMIT (TIMEOUT_PULSES)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (cnt_clear),
    .step_i  (vclk_rise),
    .hit_o   (to_hit)
  );

  mxc_addr_rx #(
    .W       (BYTE_W),
    .CTRL_ID (CTRL_ID)
  ) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .listen_i   (mode_q != MODE_BIDIR),
    .scl_lvl_i  (lvl[LINE_SCL]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_lvl_i  (lvl[LINE_SDA]),
    .sda_rise_i (sda_rise),
    .sda_fall_i (sda_fall),
    .hit_o      (id_hit),
    .oe_o       (sda_oe_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_STREAM;
      restart_q <= 1'b0;
    end else begin
      restart_q <= 1'b0;
      unique case (mode_q)
        MODE_STREAM: if (scl_fall) mode_q <= MODE_PROBE;
        MODE_PROBE: begin
          if (id_hit) begin
            mode_q <= MODE_BIDIR;
          end else if (to_hit && lvl[LINE_SCL]) begin
            mode_q    <= MODE_STREAM;
            restart_q <= 1'b1;
          end
        end
        MODE_BIDIR: mode_q <= MODE_BIDIR;
        default:    mode_q <= MODE_STREAM;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign stream_en_o = (mode_q == MODE_STREAM);
  assign restart_o   = restart_q;
  assign wr_allow_o  = (mode_q == MODE_BIDIR) && lvl[LINE_VCLK];

  p_bidir_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BIDIR) |=> (mode_q == MODE_BIDIR));

  p_stay_stream_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STREAM && !scl_fall) |=> (mode_q == MODE_STREAM));

  p_idle_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PROBE && !lvl[LINE_SCL]) |=> (mode_q != MODE_STREAM));

  p_restart_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |=> !restart_q);

  p_restart_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_q |-> (mode_q == MODE_STREAM && $past(mode_q) == MODE_PROBE));

  p_no_ack_in_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STREAM) |-> !sda_oe_o);

endmodule

// File: tb/sim_mode_xfer_ctrl.sv
module sim_mode_xfer_ctrl;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, vclk, scl, m_sda;
  logic [1:0] mode;
  logic       stream_en, restart, wr_allow, oe;
  logic       sda_bus;

  assign sda_bus = m_sda & ~oe;

  mode_xfer_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .vclk_i      (vclk),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .mode_o      (mode),
    .stream_en_o (stream_en),
    .restart_o   (restart),
    .wr_allow_o  (wr_allow),
    .sda_oe_o    (oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  int restarts = 0;

  always @(posedge clk) if (rst_n && restart) restarts++;

  // {control byte, expected ack, expected mode afterwards}
  localparam logic [10:0] VEC [0:7] = '{
    {8'hA0, 1'b1, 2'b10},
    {8'hA1, 1'b1, 2'b10},
    {8'hA2, 1'b0, 2'b01},
    {8'h20, 1'b0, 2'b01},
    {8'hB0, 1'b0, 2'b01},
    {8'hE0, 1'b0, 2'b01},
    {8'h50, 1'b0, 2'b01},
    {8'hA8, 1'b0, 2'b01}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vclk = 1'b0; scl = 1'b1; m_sda = 1'b1;
    hold(4);
    rst_n = 1'b1;
    hold(6);
  endtask

  task automatic vpulses(input int n);
    for (int i = 0; i < n; i++) begin
      vclk = 1'b1; hold(3);
      vclk = 1'b0; hold(3);
    end
  endtask

  task automatic send_start();
    m_sda = 1'b1; scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    scl = 1'b0; hold();
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hold();
      scl = 1'b1; hold();
      scl = 1'b0; hold();
    end
  endtask

  task automatic ack_slot(input logic exp_ack, input string tag);
    m_sda = 1'b1; hold();
    check(tag, 32'(oe), 32'(exp_ack));
    scl = 1'b1; hold();
    check(tag, 32'(oe), 32'(exp_ack));
    scl = 1'b0; hold();
    check(tag, 32'(oe), 32'd0);
  endtask

  task automatic send_stop();
    m_sda = 1'b0; hold();
    scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int r0;
    rst_n = 1'b0; vclk = 1'b0; scl = 1'b1; m_sda = 1'b1;

    // Table walk: control byte decode and acknowledge
    for (int i = 0; i < 8; i++) begin
      do_reset();
      send_start();
      send_bits(VEC[i][10:3]);
      ack_slot(VEC[i][2], VEC[i][2] ? "R8 ack on match" : "R8 no ack on mismatch");
      send_stop();
      check(VEC[i][2] ? "R6 match enters bidir" : "R7 mismatch stays probing",
            32'(mode), 32'(VEC[i][1:0]));
    end

    // R1 reset state
    do_reset();
    check("R1 mode", 32'(mode), 32'd0);
    check("R1 stream_en", 32'(stream_en), 32'd1);
    check("R1 sda_oe", 32'(oe), 32'd0);
    check("R1 wr_allow", 32'(wr_allow), 32'd0);
    check("R1 restart", 32'(restart), 32'd0);

    // R10 write qualifier low outside bidir
    vclk = 1'b1; hold();
    check("R10 wr_allow in streaming", 32'(wr_allow), 32'd0);
    vclk = 1'b0; hold();

    // R2 SCL fall enters probing; R3 timeout at 128
    vpulses(5);
    check("R2 vclk alone keeps streaming", 32'(mode), 32'd0);
    scl = 1'b0; hold();
    check("R2 probing after scl fall", 32'(mode), 32'd1);
    check("R2 stream_en low", 32'(stream_en), 32'd0);
    scl = 1'b1; hold();
    r0 = restarts;
    vpulses(127);
    check("R3 127 pulses stay probing", 32'(mode), 32'd1);
    vpulses(1);
    check("R3 128th pulse returns to streaming", 32'(mode), 32'd0);
    check("R3 stream_en restored", 32'(stream_en), 32'd1);
    check("R3 one restart pulse", 32'(restarts - r0), 32'd1);

    // R4 SCL fall clears the count
    do_reset();
    scl = 1'b0; hold(); scl = 1'b1; hold();
    vpulses(100);
    scl = 1'b0; hold(); scl = 1'b1; hold();
    vpulses(100);
    check("R4 count cleared by scl fall", 32'(mode), 32'd1);
    vpulses(28);
    check("R4 timeout after fresh 128", 32'(mode), 32'd0);

    // R5 count full while SCL low
    do_reset();
    scl = 1'b0; hold();
    vpulses(130);
    check("R5 no return while scl low", 32'(mode), 32'd1);
    scl = 1'b1; hold();
    check("R5 return once scl idle", 32'(mode), 32'd0);

    // R7 mismatch then timeout
    do_reset();
    send_start();
    send_bits(8'hA4);
    ack_slot(1'b0, "R7 no ack");
    send_stop();
    vpulses(127);
    check("R7 still probing", 32'(mode), 32'd1);
    vpulses(1);
    check("R7 timeout after mismatch", 32'(mode), 32'd0);

    // R9 and R10 in bidirectional mode
    do_reset();
    send_start();
    send_bits(8'hA0);
    ack_slot(1'b1, "R8 ack");
    send_stop();
    vclk = 1'b1; hold();
    check("R10 wr_allow with vclk high", 32'(wr_allow), 32'd1);
    vclk = 1'b0; hold();
    check("R10 wr_allow with vclk low", 32'(wr_allow), 32'd0);
    vpulses(300);
    check("R9 vclk ignored in bidir", 32'(mode), 32'd2);
    send_start();
    send_bits(8'hA0);
    ack_slot(1'b0, "R9 no further ack in bidir");
    send_stop();
    check("R9 bidir sticky after traffic", 32'(mode), 32'd2);
    check("R9 stream_en low in bidir", 32'(stream_en), 32'd0);
    do_reset();
    check("R9 reset releases bidir", 32'(mode), 32'd0);

    summary();
  end

endmodule